// File: doc/BRIEF.md
# FP instruction class decoder

This block looks at one 32-bit instruction word and sorts it into an execution class for a floating-point and graphics unit. Seven classes are possible: floating-point operate, move on FP condition codes, move on an integer register condition, fused multiply-add, graphics operation, integer-side FP-related operation, or other. Alongside the class it raises an unimplemented flag and reports the operand precision, so that a trap handler or an emulation loop can decide at once whether to run, reject or skip the instruction.

The integer-side class covers the few non-FP instructions (status register access, FP branches, FP loads and stores, integer moves on FP conditions) that an emulation loop can step through without leaving emulation. The unimplemented check depends on the opcode, the precision field and the immediate bit together. The decode itself is combinational. A parameter adds an output register, which is present by default.

Top module: `fpcls_decode`

## Requirements
- R1: `cls_o` is one-hot with exactly one bit set: bit 0 FP-operate, bit 1 move on FP condition codes, bit 2 move on register condition, bit 3 fused multiply-add, bit 4 graphics, bit 5 integer-side, bit 6 other.
- R2: With bits 31:30 equal to 2, an op3 field (bits 24:19) of 0x34 or 0x35 selects FP-operate (unless R3 applies), 0x37 selects fused multiply-add and 0x36 selects graphics.
- R3: With op3 0x35, an opcode field (bits 12:7) whose low four bits are zero is a move on FP condition codes; otherwise, low three bits equal to 1 make it a move on register condition. Either move is unimplemented only when the precision field (bits 6:5) is 0, whatever the immediate bit.
- R4: An FP-operate instruction with the immediate bit (bit 13) set is unimplemented.
- R5: An FP-operate instruction with precision 0 is unimplemented unless its opcode is an integer-to-float conversion: 0x21, 0x22, 0x23 (from 64-bit) or 0x31, 0x32, 0x33 (from 32-bit).
- R6: Opcode 0x1A (single-to-double multiply) is unimplemented unless precision is 1; opcode 0x1B (double-to-quad multiply) is unimplemented unless precision is 2.
- R7: An FP-operate opcode outside the set 0x00, 0x01, 0x02, 0x0A, 0x10 to 0x15, 0x1A, 0x1B, 0x20 to 0x23, 0x31 to 0x34 is unimplemented.
- R8: Fused multiply-add, graphics, integer-side and other instructions never raise the unimplemented flag.
- R9: `prec_o` equals bits 6:5 for FP-operate, both moves and fused multiply-add (where these bits are the size field), and is 0 for the other classes.
- R10: Integer-side is: bits 31:30 = 2 with op3 0x28 and bits 18:14 = 0x13; bits 31:30 = 2 with op3 0x30 and bits 29:25 = 0x13; bits 31:30 = 2 with op3 0x2C and bit 18 clear; bits 31:30 = 0 with bits 24:22 equal to 5 or 6; bits 31:30 = 3 with op3 AND 0x38 equal to 0x20.
- R11: Any word that no rule above matches is class other.
- R12: With the output register on (default), outputs follow the instruction one rising clock edge later; while `rst_n` is low at an edge they take class other, unimplemented 0, precision 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| insn_i | input | 32 | Instruction word to classify |
| cls_o | output | 7 | One-hot execution class |
| unimpl_o | output | 1 | Instruction is unimplemented in its class |
| prec_o | output | 2 | Operand precision or fused multiply-add size |

## Verification
All three results are due together at the first rising edge after the word is applied, so with the default register they are valid at the falling edge one cycle after the drive. The driver records each expected result with the cycle number it falls due in, and the monitor compares only when the cycle counter reaches that number, sampling at the falling edge away from the register update. The reset values are read while reset is held, before any expected item is queued.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;

   // instruction field positions
   localparam int unsigned TOP_W    = 2;
   localparam int unsigned TOP_LSB  = 30;
   localparam int unsigned RD_W     = 5;
   localparam int unsigned RD_LSB   = 25;
   localparam int unsigned OP3_W    = 6;
   localparam int unsigned OP3_LSB  = 19;
   localparam int unsigned RS1_W    = 5;
   localparam int unsigned RS1_LSB  = 14;
   localparam int unsigned IBIT_POS = 13;
   localparam int unsigned OPC_W    = 6;
   localparam int unsigned OPC_LSB  = 7;
   localparam int unsigned PREC_W   = 2;
   localparam int unsigned PREC_LSB = 5;

   // class bit indices
   localparam int unsigned CLS_N   = 7;
   localparam int unsigned C_FPOP  = 0;
   localparam int unsigned C_CCMOV = 1;
   localparam int unsigned C_RCMOV = 2;
   localparam int unsigned C_FMA   = 3;
   localparam int unsigned C_GFX   = 4;
   localparam int unsigned C_INTS  = 5;
   localparam int unsigned C_OTHER = 6;

   localparam logic [TOP_W-1:0] TOP_ARITH = 2'd2;
   localparam logic [TOP_W-1:0] TOP_BRCH  = 2'd0;
   localparam logic [TOP_W-1:0] TOP_MEM   = 2'd3;

   localparam logic [OP3_W-1:0] OP3_OPA    = 6'h34;
   localparam logic [OP3_W-1:0] OP3_OPB    = 6'h35;
   localparam logic [OP3_W-1:0] OP3_GFX    = 6'h36;
   localparam logic [OP3_W-1:0] OP3_FMA    = 6'h37;
   localparam logic [OP3_W-1:0] OP3_STRD   = 6'h28;
   localparam logic [OP3_W-1:0] OP3_STWR   = 6'h30;
   localparam logic [OP3_W-1:0] OP3_IMOVF  = 6'h2C;
   localparam logic [OP3_W-1:0] MEM_MASK   = 6'h38;
   localparam logic [OP3_W-1:0] MEM_MATCH  = 6'h20;
   localparam logic [RS1_W-1:0] STAT_SEL   = 5'h13;
   localparam logic [2:0]       BR_PREDICT = 3'd5;
   localparam logic [2:0]       BR_PLAIN   = 3'd6;

   localparam logic [OPC_W-1:0] OPC_S2D_MUL = 6'h1A;
   localparam logic [OPC_W-1:0] OPC_D2Q_MUL = 6'h1B;

   localparam int unsigned N_KNOWN = 20;
   localparam logic [OPC_W-1:0] KNOWN_OPC [N_KNOWN] = '{
      6'h00, 6'h01, 6'h02, 6'h0A, 6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15,
      6'h1A, 6'h1B, 6'h20, 6'h21, 6'h22, 6'h23, 6'h31, 6'h32, 6'h33, 6'h34};

   localparam int unsigned N_CONV = 6;
   localparam logic [OPC_W-1:0] CONV_OPC [N_CONV] = '{
      6'h21, 6'h22, 6'h23, 6'h31, 6'h32, 6'h33};

   typedef struct packed {
      logic [TOP_W-1:0]  top;
      logic [RD_W-1:0]   rd;
      logic [OP3_W-1:0]  op3;
      logic [RS1_W-1:0]  rs1;
      logic              ibit;
      logic [OPC_W-1:0]  opc;
      logic [PREC_W-1:0] prec;
   } fields_t;

   localparam logic [CLS_N-1:0] CLS_RST = CLS_N'(1) << C_OTHER;

endpackage

// File: rtl/fpcls_fields.sv
module fpcls_fields
   import fpcls_pkg::*;
#(
   parameter int unsigned INSN_W = 32
) (
   input  logic [INSN_W-1:0] insn_i,
   output fields_t           fld_o
);

   if (INSN_W != TOP_LSB + TOP_W) begin : g_bad_width
      $error("fpcls_fields: INSN_W must equal %0d", TOP_LSB + TOP_W);
   end

   assign fld_o.top  = insn_i[TOP_LSB  +: TOP_W];
   assign fld_o.rd   = insn_i[RD_LSB   +: RD_W];
   assign fld_o.op3  = insn_i[OP3_LSB  +: OP3_W];
   assign fld_o.rs1  = insn_i[RS1_LSB  +: RS1_W];
   assign fld_o.ibit = insn_i[IBIT_POS];
   assign fld_o.opc  = insn_i[OPC_LSB  +: OPC_W];
   assign fld_o.prec = insn_i[PREC_LSB +: PREC_W];

   // register-source bits take no part in the class decision
   logic unused_low;
   assign unused_low = ^insn_i[PREC_LSB-1:0];

endmodule

// File: rtl/fpcls_classify.sv
module fpcls_classify
   import fpcls_pkg::*;
(
   input  fields_t          fld_i,
   output logic [CLS_N-1:0] cls_o
);

   logic arith, fp_grp, in_opb;
   logic ints_rd, ints_wr, ints_mov, ints_br, ints_mem, ints_any;

   assign arith   = (fld_i.top == TOP_ARITH);
   assign fp_grp  = arith && ((fld_i.op3 == OP3_OPA) || (fld_i.op3 == OP3_OPB));
   assign in_opb  = (fld_i.op3 == OP3_OPB);

   // integer-side instructions an emulation loop may step through
   assign ints_rd  = arith && (fld_i.op3 == OP3_STRD) && (fld_i.rs1 == STAT_SEL);
   assign ints_wr  = arith && (fld_i.op3 == OP3_STWR) && (fld_i.rd == STAT_SEL);
   assign ints_mov = arith && (fld_i.op3 == OP3_IMOVF) && !fld_i.rs1[RS1_W-1];
   assign ints_br  = (fld_i.top == TOP_BRCH) &&
                     ((fld_i.op3[OP3_W-1 -: 3] == BR_PREDICT) ||
                      (fld_i.op3[OP3_W-1 -: 3] == BR_PLAIN));
   assign ints_mem = (fld_i.top == TOP_MEM) && ((fld_i.op3 & MEM_MASK) == MEM_MATCH);
   assign ints_any = ints_rd | ints_wr | ints_mov | ints_br | ints_mem;

   always_comb begin
      cls_o = '0;
      if (fp_grp) begin
         if (in_opb && (fld_i.opc[3:0] == 4'd0))
            cls_o[C_CCMOV] = 1'b1;
         else if (in_opb && (fld_i.opc[2:0] == 3'd1))
            cls_o[C_RCMOV] = 1'b1;
         else
            cls_o[C_FPOP] = 1'b1;
      end else if (arith && (fld_i.op3 == OP3_FMA)) begin
         cls_o[C_FMA] = 1'b1;
      end else if (arith && (fld_i.op3 == OP3_GFX)) begin
         cls_o[C_GFX] = 1'b1;
      end else if (ints_any) begin
         cls_o[C_INTS] = 1'b1;
      end else begin
         cls_o[C_OTHER] = 1'b1;
      end
   end

   logic unused_cls_fld;
   assign unused_cls_fld = ^{fld_i.ibit, fld_i.opc[OPC_W-1:4], fld_i.prec};

endmodule

// File: rtl/fpcls_opchk.sv
module fpcls_opchk
   import fpcls_pkg::*;
(
   input  fields_t          fld_i,
   input  logic [CLS_N-1:0] cls_i,
   output logic             unimpl_o
);

   logic [N_KNOWN-1:0] hit_known;
   logic [N_CONV-1:0]  hit_conv;

   for (genvar gi = 0; gi < N_KNOWN; gi++) begin : g_known
      assign hit_known[gi] = (fld_i.opc == KNOWN_OPC[gi]);
   end

   for (genvar gj = 0; gj < N_CONV; gj++) begin : g_conv
      assign hit_conv[gj] = (fld_i.opc == CONV_OPC[gj]);
   end

   logic prec_zero, bad_prec0, bad_s2d, bad_d2q;

   assign prec_zero = (fld_i.prec == '0);
   assign bad_prec0 = prec_zero && !(|hit_conv);
   assign bad_s2d   = (fld_i.opc == OPC_S2D_MUL) && (fld_i.prec != PREC_W'(1));
   assign bad_d2q   = (fld_i.opc == OPC_D2Q_MUL) && (fld_i.prec != PREC_W'(2));

   always_comb begin
      unimpl_o = 1'b0;
      if (cls_i[C_CCMOV] || cls_i[C_RCMOV])
         unimpl_o = prec_zero;
      else if (cls_i[C_FPOP])
         unimpl_o = fld_i.ibit | bad_prec0 | bad_s2d | bad_d2q | !(|hit_known);
   end

   logic unused_chk;
   assign unused_chk = ^{fld_i.top, fld_i.rd, fld_i.op3, fld_i.rs1, cls_i[CLS_N-1:C_FMA]};

endmodule

// File: rtl/fpcls_decode.sv
module fpcls_decode
   import fpcls_pkg::*;
#(
   parameter int unsigned INSN_W  = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] insn_i,
   output logic [CLS_N-1:0]  cls_o,
   output logic              unimpl_o,
   output logic [PREC_W-1:0] prec_o
);

   if (INSN_W != 32) begin : g_bad_insn_w
      $error("fpcls_decode: INSN_W must be 32");
   end

   fields_t           fld;
   logic [CLS_N-1:0]  cls_c;
   logic              unimpl_c;
   logic [PREC_W-1:0] prec_c;

   fpcls_fields #(.INSN_W(INSN_W)) u_fields (
      .insn_i (insn_i),
      .fld_o  (fld)
   );

   fpcls_classify u_classify (
      .fld_i (fld),
      .cls_o (cls_c)
   );

   fpcls_opchk u_opchk (
      .fld_i    (fld),
      .cls_i    (cls_c),
      .unimpl_o (unimpl_c)
   );

   logic keep_prec;
   assign keep_prec = cls_c[C_FPOP] | cls_c[C_CCMOV] | cls_c[C_RCMOV] | cls_c[C_FMA];
   assign prec_c    = keep_prec ? fld.prec : '0;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cls_o    <= CLS_RST;
            unimpl_o <= 1'b0;
            prec_o   <= '0;
         end else begin
            cls_o    <= cls_c;
            unimpl_o <= unimpl_c;
            prec_o   <= prec_c;
         end
      end

      // set once an edge out of reset has loaded real decode results
      logic hist_q;
      always_ff @(posedge clk) begin
         if (!rst_n) hist_q <= 1'b0;
         else        hist_q <= 1'b1;
      end

      p_fma_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
         hist_q && $past(insn_i[TOP_LSB +: TOP_W] == TOP_ARITH &&
                         insn_i[OP3_LSB +: OP3_W] == OP3_FMA)
         |-> cls_o[C_FMA] && !unimpl_o)
         else $error("fused multiply-add word not routed one edge later");

      p_gfx_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
         hist_q && $past(insn_i[TOP_LSB +: TOP_W] == TOP_ARITH &&
                         insn_i[OP3_LSB +: OP3_W] == OP3_GFX)
         |-> cls_o[C_GFX])
         else $error("graphics word not routed one edge later");

      p_ibit_unimpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
         hist_q && $past(insn_i[TOP_LSB +: TOP_W] == TOP_ARITH &&
                         insn_i[OP3_LSB +: OP3_W] == OP3_OPA &&
                         insn_i[IBIT_POS])
         |-> cls_o[C_FPOP] && unimpl_o)
         else $error("immediate bit on FP-operate not flagged");
   end else begin : g_comb
      assign cls_o    = cls_c;
      assign unimpl_o = unimpl_c;
      assign prec_o   = prec_c;

      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
   end

   p_cls_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cls_o) == 1)
      else $error("class output not one-hot");

   p_unimpl_scope_r8: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl_o |-> (cls_o[C_FPOP] | cls_o[C_CCMOV] | cls_o[C_RCMOV]))
      else $error("unimplemented raised outside FP-operate and moves");

   p_prec_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_o[C_GFX] | cls_o[C_INTS] | cls_o[C_OTHER]) |-> (prec_o == '0))
      else $error("precision nonzero for a non-FP class");

endmodule

// File: tb/tb_fpcls_decode.sv
module tb_fpcls_decode;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] insn;
   logic [6:0]  cls;
   logic        unimpl;
   logic [1:0]  prec;

   always #5 clk = ~clk;

   fpcls_decode dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .insn_i   (insn),
      .cls_o    (cls),
      .unimpl_o (unimpl),
      .prec_o   (prec)
   );

   typedef struct {
      logic [6:0] c;
      logic       u;
      logic [1:0] p;
      int         due;
      string      tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   total = 0;
   int   bad = 0;
   bit   finished = 1'b0;

   always @(posedge clk) cyc++;

   // reference built from the requirement list
   function automatic bit known_op(input logic [5:0] o);
      case (o)
         6'h00, 6'h01, 6'h02, 6'h0A: return 1'b1;
         6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15: return 1'b1;
         6'h1A, 6'h1B: return 1'b1;
         6'h20, 6'h21, 6'h22, 6'h23: return 1'b1;
         6'h31, 6'h32, 6'h33, 6'h34: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit int_conv(input logic [5:0] o);
      return (o == 6'h21) || (o == 6'h22) || (o == 6'h23) ||
             (o == 6'h31) || (o == 6'h32) || (o == 6'h33);
   endfunction

   function automatic void ref_model(input logic [31:0] w, output logic [6:0] c,
                                     output logic u, output logic [1:0] p);
      logic [1:0] t;
      logic [5:0] o3;
      logic [5:0] oc;
      logic [1:0] pr;
      t  = w[31:30];
      o3 = w[24:19];
      oc = w[12:7];
      pr = w[6:5];
      c = 7'd0; u = 1'b0; p = 2'd0;
      if (t == 2'd2 && o3 == 6'h35 && oc[3:0] == 4'd0) begin
         c = 7'b0000010; u = (pr == 2'd0); p = pr;
      end else if (t == 2'd2 && o3 == 6'h35 && oc[2:0] == 3'd1) begin
         c = 7'b0000100; u = (pr == 2'd0); p = pr;
      end else if (t == 2'd2 && (o3 == 6'h34 || o3 == 6'h35)) begin
         c = 7'b0000001; p = pr;
         u = w[13] || !known_op(oc) || (pr == 2'd0 && !int_conv(oc)) ||
             (oc == 6'h1A && pr != 2'd1) || (oc == 6'h1B && pr != 2'd2);
      end else if (t == 2'd2 && o3 == 6'h37) begin
         c = 7'b0001000; p = pr;
      end else if (t == 2'd2 && o3 == 6'h36) begin
         c = 7'b0010000;
      end else if ((t == 2'd2 && o3 == 6'h28 && w[18:14] == 5'h13) ||
                   (t == 2'd2 && o3 == 6'h30 && w[29:25] == 5'h13) ||
                   (t == 2'd2 && o3 == 6'h2C && !w[18]) ||
                   (t == 2'd0 && (w[24:22] == 3'd5 || w[24:22] == 3'd6)) ||
                   (t == 2'd3 && (o3 & 6'h38) == 6'h20)) begin
         c = 7'b0100000;
      end else begin
         c = 7'b1000000;
      end
   endfunction

   function automatic logic [31:0] w3(input logic [1:0] t, input logic [4:0] rd,
                                      input logic [5:0] o3, input logic [4:0] rs1,
                                      input logic ib, input logic [5:0] oc,
                                      input logic [1:0] pr);
      return {t, rd, o3, rs1, ib, oc, pr, 5'd7};
   endfunction

   function automatic logic [31:0] wfma(input logic [4:0] rs3, input logic [1:0] vr,
                                        input logic [1:0] sz);
      return {2'd2, 5'd4, 6'h37, 5'd9, rs3, vr, sz, 5'd2};
   endfunction

   function automatic logic [31:0] wbr(input logic [2:0] op2);
      return {2'd0, 1'b0, 4'd3, op2, 22'h01234};
   endfunction

   task automatic drive(input logic [31:0] w, input string tag);
      exp_t e;
      @(negedge clk);
      insn = w;
      ref_model(w, e.c, e.u, e.p);
      e.due = cyc + 1;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compares each result at the falling edge of its due cycle
   always @(negedge clk) begin
      exp_t e;
      if (sb.size() > 0 && sb[0].due == cyc) begin
         e = sb.pop_front();
         total++;
         if (cls !== e.c || unimpl !== e.u || prec !== e.p) begin
            bad++;
            $display("FAIL %s: got cls=%b unimpl=%b prec=%0d, expected cls=%b unimpl=%b prec=%0d",
                     e.tag, cls, unimpl, prec, e.c, e.u, e.p);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      insn  = w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h10, 2'd2);
      repeat (3) @(negedge clk);
      // R12 reset values
      total++;
      if (cls !== 7'b1000000 || unimpl !== 1'b0 || prec !== 2'd0) begin
         bad++;
         $display("FAIL R12 reset: got cls=%b unimpl=%b prec=%0d, expected cls=1000000 unimpl=0 prec=0",
                  cls, unimpl, prec);
      end
      rst_n = 1'b1;

      // R2 FP-operate group
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h10, 2'd1), "R2 add single");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h10, 2'd3), "R9 add quad prec");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h0A, 2'd2), "R2 sqrt double");
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b0, 6'h14, 2'd1), "R2 compare in second group");
      // R4 immediate bit
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b1, 6'h10, 2'd1), "R4 ibit set");
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b1, 6'h15, 2'd2), "R4 ibit second group");
      // R5 precision zero
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h10, 2'd0), "R5 prec0 add");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h31, 2'd0), "R5 int32 to single");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h22, 2'd0), "R5 int64 to double");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h33, 2'd0), "R5 int32 to quad");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h34, 2'd0), "R5 to-int prec0");
      // R6 widening multiplies
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h1A, 2'd1), "R6 s2d ok");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h1A, 2'd2), "R6 s2d bad prec");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h1B, 2'd2), "R6 d2q ok");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h1B, 2'd1), "R6 d2q bad prec");
      // R7 unknown opcodes
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h3F, 2'd1), "R7 opcode 3F");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h16, 2'd2), "R7 opcode 16");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h20, 2'd1), "R7 known 20");
      // R3 moves in the second group
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b0, 6'h00, 2'd1), "R3 ccmove");
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b0, 6'h10, 2'd2), "R3 ccmove opc 10");
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b0, 6'h20, 2'd0), "R3 ccmove prec0");
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b1, 6'h00, 2'd3), "R3 ccmove ibit ignored");
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b0, 6'h01, 2'd2), "R3 rmove");
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b0, 6'h09, 2'd1), "R3 rmove opc 09");
      drive(w3(2'd2, 5'd1, 6'h35, 5'd2, 1'b0, 6'h11, 2'd0), "R3 rmove prec0");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h00, 2'd1), "R3 first group no move");
      // R8 fused multiply-add and graphics
      drive(wfma(5'h1F, 2'd0, 2'd0), "R8 fma size0");
      drive(wfma(5'h10, 2'd3, 2'd2), "R8 fma size2");
      drive(wfma(5'h00, 2'd1, 2'd3), "R9 fma size3");
      drive(w3(2'd2, 5'd1, 6'h36, 5'd2, 1'b1, 6'h00, 2'd3), "R9 graphics prec zero");
      // R10 integer-side
      drive(w3(2'd2, 5'd1, 6'h28, 5'h13, 1'b0, 6'h00, 2'd0), "R10 read status");
      drive(w3(2'd2, 5'd1, 6'h28, 5'h12, 1'b0, 6'h00, 2'd0), "R11 read other reg");
      drive(w3(2'd2, 5'h13, 6'h30, 5'd2, 1'b0, 6'h00, 2'd1), "R10 write status");
      drive(w3(2'd2, 5'h12, 6'h30, 5'd2, 1'b0, 6'h00, 2'd1), "R11 write other reg");
      drive(w3(2'd2, 5'd1, 6'h2C, 5'h0F, 1'b0, 6'h00, 2'd2), "R10 int move bit18 clear");
      drive(w3(2'd2, 5'd1, 6'h2C, 5'h10, 1'b0, 6'h00, 2'd2), "R11 int move bit18 set");
      drive(wbr(3'd5), "R10 predicted branch");
      drive(wbr(3'd6), "R10 plain branch");
      drive(wbr(3'd4), "R11 other op2");
      drive(w3(2'd3, 5'd1, 6'h20, 5'd2, 1'b0, 6'h00, 2'd1), "R10 mem 20");
      drive(w3(2'd3, 5'd1, 6'h27, 5'd2, 1'b0, 6'h00, 2'd1), "R10 mem 27");
      drive(w3(2'd3, 5'd1, 6'h30, 5'd2, 1'b0, 6'h00, 2'd1), "R11 mem 30");
      // R11 fallthrough
      drive(w3(2'd1, 5'd1, 6'h34, 5'd2, 1'b0, 6'h10, 2'd1), "R11 top bits 1");
      drive(w3(2'd3, 5'd1, 6'h34, 5'd2, 1'b0, 6'h10, 2'd1), "R11 top bits 3 op3 34");
      drive(w3(2'd2, 5'd1, 6'h00, 5'd2, 1'b0, 6'h00, 2'd2), "R11 plain alu");
      // R1 back-to-back class changes
      drive(wfma(5'h01, 2'd2, 2'd1), "R1 fma then");
      drive(w3(2'd2, 5'd1, 6'h36, 5'd2, 1'b0, 6'h00, 2'd0), "R1 graphics then");
      drive(w3(2'd2, 5'd1, 6'h34, 5'd2, 1'b0, 6'h13, 2'd2), "R1 divide");

      repeat (4) @(negedge clk);
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL R12 pending results never compared: %0d left, expected 0", sb.size());
      end
      finish_run();
   end

   initial begin
      #200000;
      if (!finished) begin
         bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         finish_run();
      end
   end

endmodule